// File: doc/BRIEF.md
# MDIO Station-Management Command Master

This block lets software reach the management registers of an Ethernet PHY through a single packed command register. A write to that register names the PHY, the register inside it, the direction and, for a write, sixteen bits of data. The block then produces the management clock and shifts out a complete Clause 22 frame, releasing the data line when the PHY has to answer. The same register reports progress: a busy bit while the frame runs, and a read-valid bit once read data has been captured into its low half.

A second, narrow register holds the station's own 5-bit PHY address. It can be read and rewritten at any time, whether or not a frame is running. The management clock runs only while a frame is in flight and is derived from the system clock by an even divide ratio set by a parameter.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the busy and read-valid bits read 0, the stored command fields read 0, the own-address register reads 0, and MDC, MDIO output and MDIO output enable are all low.
- R2: With reg_sel=0, rd_data returns data in [15:0], PHY address in [20:16], register number in [25:21], opcode in [27:26], busy in [28], read-valid in [29], and 0 in [31:30].
- R3: A command accepted at a clock edge sets busy from that edge for exactly 64*DIV cycles; busy then reads 0.
- R4: MDC is low whenever busy is 0; during a frame each bit lasts DIV cycles, MDC low for the first DIV/2 and high for the last DIV/2.
- R5: The frame is, in time order: 32 ones, start 0 then 1, the opcode ([27] first), PHY address MSB first, register number MSB first, two turnaround bits, 16 data bits MSB first; MDIO changes only at bit boundaries, where MDC falls.
- R6: For opcode 01 (write) the output enable stays high for all 64 bits, the turnaround is driven 1 then 0, the data bits come from command [15:0], and read-valid stays 0.
- R7: For opcode 10 (read) the output enable and MDIO output are low from the first turnaround bit (bit 46) to the end; mdio_i is sampled at each MDC rise of bits 48 to 63, and when busy clears the 16 sampled bits (first sample as bit 15) appear in [15:0] with read-valid set.
- R8: Read-valid is cleared in the cycle after any new command is accepted.
- R9: A command-register write while busy is 1 is ignored: stored fields, data and the running frame are unaffected.
- R10: A command-register write with opcode 00 or 11 starts nothing and changes no stored field.
- R11: With reg_sel=1 a write loads wr_data[4:0] into the own-address register (upper bits ignored), accepted even while busy; rd_data returns it in [4:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects command register, 1 selects own-address register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data returned from the PHY |

## Verification
Every register in the path adds one edge: a command taken at an edge shows busy and the first preamble bit right after it, MDC rises DIV/2 edges into each bit, and busy, read data and read-valid all change at the edge that closes the 64th bit, 64*DIV edges after acceptance. The bench's model steps once per rising edge and all outputs are compared a few nanoseconds later, after the design has settled, so each comparison lands on the exact cycle a result is due. Stimulus and the PHY's answer bits change only on falling edges, away from both sampling points.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  localparam int F_DATA_LSB = 0;
  localparam int F_PHY_LSB  = 16;
  localparam int F_REG_LSB  = 21;
  localparam int F_OP_LSB   = 26;
  localparam int F_BUSY     = 28;
  localparam int F_RVALID   = 29;

  typedef enum logic [1:0] {
    OP_RSV0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSV3  = 2'b11
  } mdio_op_e;

  function automatic logic op_is_valid(input logic [1:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  // Whole frame, first bit on the wire in bit 63.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic [1:0]  op,
    input logic [4:0]  phy,
    input logic [4:0]  regn,
    input logic [15:0] data
  );
    logic [1:0]  ta;
    logic [15:0] payload;
    ta      = (op == OP_READ) ? 2'b11 : 2'b10;
    payload = (op == OP_READ) ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic bit_end
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] PRE_R = CW'(HALF - 1);
  localparam logic [CW-1:0] HALFC = CW'(HALF);

  logic [CW-1:0] cnt;

  initial begin
    if (DIV < 2 || (DIV % 2) != 0)
      $error("mdio_clkgen: DIV must be even and at least 2");
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign mdc      = run && (cnt >= HALFC);
  assign rise_evt = run && (cnt == PRE_R);
  assign bit_end  = run && (cnt == LAST);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_frame,
  input  logic                  load_rd,
  input  logic                  bit_end,
  input  logic                  rise_evt,
  input  logic                  mdc,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [15:0]           cap
);
  logic [FRAME_BITS-1:0] sh;
  logic [5:0]            idx;
  logic                  rd_q;
  logic                  in_data;

  assign in_data = idx >= 6'(DATA_FIRST);
  assign done    = busy && bit_end && (idx == 6'(FRAME_BITS - 1));
  assign mdio_oe = busy && (!rd_q || (idx < 6'(TA_FIRST)));
  assign mdio_o  = mdio_oe && sh[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      idx  <= '0;
      rd_q <= 1'b0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= load_frame;
      idx  <= '0;
      rd_q <= load_rd;
      busy <= 1'b1;
    end else if (busy && bit_end) begin
      sh  <= {sh[FRAME_BITS-2:0], 1'b0};
      idx <= idx + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cap <= '0;
    else if (busy && rise_evt && rd_q && in_data)
      cap <= {cap[14:0], mdio_i};
  end

  AST_MDIO_HELD_WHILE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && $past(mdc)) |-> $stable(mdio_o)); // R5
  AST_BUSY_ENDS_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == 6'(FRAME_BITS - 1))); // R3
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int DIV = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [4:0]  phy_q, regn_q, own_q;
  logic [1:0]  op_q;
  logic [15:0] data_q;
  logic        rvalid_q;

  logic        busy, done, rise_evt, bit_end;
  logic [15:0] cap;
  logic [1:0]  in_op;
  logic        accept;
  logic [FRAME_BITS-1:0] frame;

  assign in_op  = wr_data[F_OP_LSB +: 2];
  assign accept = wr_en && !reg_sel && !busy && op_is_valid(in_op);
  assign frame  = build_frame(in_op, wr_data[F_PHY_LSB +: 5],
                              wr_data[F_REG_LSB +: 5], wr_data[F_DATA_LSB +: 16]);

  mdio_clkgen #(.DIV(DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .bit_end  (bit_end)
  );

  mdio_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_frame (frame),
    .load_rd    (in_op == OP_READ),
    .bit_end    (bit_end),
    .rise_evt   (rise_evt),
    .mdc        (mdc),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .done       (done),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .cap        (cap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q    <= '0;
      regn_q   <= '0;
      op_q     <= '0;
      data_q   <= '0;
      rvalid_q <= 1'b0;
    end else if (accept) begin
      phy_q    <= wr_data[F_PHY_LSB +: 5];
      regn_q   <= wr_data[F_REG_LSB +: 5];
      op_q     <= in_op;
      data_q   <= wr_data[F_DATA_LSB +: 16];
      rvalid_q <= 1'b0;
    end else if (done && op_q == OP_READ) begin
      data_q   <= cap;
      rvalid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 own_q <= '0;
    else if (wr_en && reg_sel)  own_q <= wr_data[4:0];
  end

  always_comb begin
    rd_data = '0;
    if (reg_sel) begin
      rd_data[4:0] = own_q;
    end else begin
      rd_data[F_DATA_LSB +: 16] = data_q;
      rd_data[F_PHY_LSB +: 5]   = phy_q;
      rd_data[F_REG_LSB +: 5]   = regn_q;
      rd_data[F_OP_LSB +: 2]    = op_q;
      rd_data[F_BUSY]           = busy;
      rd_data[F_RVALID]         = rvalid_q;
    end
  end

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R4
  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wr_en) && !$past(reg_sel))); // R3
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid_q) |-> (op_q == OP_READ)); // R7
  AST_FIELDS_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(phy_q) && $stable(regn_q) && $stable(op_q))); // R9
endmodule

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
  localparam int DIVB = 8;
  localparam int FRAME_CYC = 64 * DIVB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;

  mdio_cmd_master #(.DIV(DIVB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  // behavioural model state
  bit          m_busy;
  int          m_t;
  bit [1:0]    m_op;
  bit [4:0]    m_phy, m_reg, m_own;
  bit [15:0]   m_data, m_cap, m_resp;
  bit          m_rv;

  function automatic bit wire_bit(int k);
    if (k < 32) return 1'b1;
    if (k == 32) return 1'b0;
    if (k == 33) return 1'b1;
    if (k < 36) return m_op[35 - k];
    if (k < 41) return m_phy[40 - k];
    if (k < 46) return m_reg[45 - k];
    if (k == 46) return 1'b1;
    if (k == 47) return 1'b0;
    return m_data[63 - k];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int k, c;
    bit e_oe;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_op = 0; m_phy = 0; m_reg = 0; m_own = 0;
      m_data = 0; m_cap = 0; m_rv = 0;
    end else begin
      if (m_busy) begin
        k = m_t / DIVB; c = m_t % DIVB;
        if (c == DIVB/2 - 1 && m_op == 2'b10 && k >= 48) m_cap = {m_cap[14:0], mdio_i};
        m_t++;
        if (m_t == FRAME_CYC) begin
          m_busy = 0;
          if (m_op == 2'b10) begin m_data = m_cap; m_rv = 1; end
        end
      end else if (wr_en && !reg_sel && (wr_data[27:26] == 2'b01 || wr_data[27:26] == 2'b10)) begin
        m_busy = 1; m_t = 0; m_op = wr_data[27:26];
        m_phy = wr_data[20:16]; m_reg = wr_data[25:21]; m_data = wr_data[15:0];
        m_rv = 0;
      end
      if (wr_en && reg_sel) m_own = wr_data[4:0];
    end
    #3;
    if (rst_n) begin
      k = m_t / DIVB; c = m_t % DIVB;
      e_oe = m_busy && (m_op == 2'b01 || k < 46);
      check("R4 mdc", 32'(mdc), 32'(m_busy && c >= DIVB/2));
      check("R3 busy", 32'(rd_data[28] & ~reg_sel), 32'(m_busy & ~reg_sel));
      check("R5 oe", 32'(mdio_oe), 32'(e_oe));
      check("R5 mdio", 32'(mdio_o), 32'(e_oe && wire_bit(k)));
      if (reg_sel) check("R11 own", rd_data, {27'd0, m_own});
      else check("R2 cmd", rd_data, {2'b00, m_rv, m_busy, m_op, m_reg, m_phy, m_data});
    end
  end

  // PHY answer: changes on falling edges only
  always @(negedge clk) begin
    int k;
    k = m_t / DIVB;
    if (m_busy && m_op == 2'b10 && k >= 48) mdio_i <= m_resp[63 - k];
    else mdio_i <= 1'b1;
  end

  task automatic wr(bit sel, logic [31:0] val);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 1'b0;
  endtask

  function automatic logic [31:0] cmd(bit [1:0] op, bit [4:0] phy, bit [4:0] rg, bit [15:0] d);
    return {4'b0, op, rg, phy, d};
  endfunction

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports, before release
    #1;
    check("R1 mdc", 32'(mdc), 0);
    check("R1 oe", 32'(mdio_oe), 0);
    check("R1 cmd", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    reg_sel = 1'b1; #1;
    check("R1 own", rd_data, 0);
    reg_sel = 1'b0;

    // R11: own address, upper bits dropped
    wr(1'b1, 32'hFFFF_FFE5);
    reg_sel = 1'b1; #1;
    check("R11 own readback", rd_data, 32'h0000_0005);
    reg_sel = 1'b0;

    // R6: write frame, then an ignored command mid-frame (R9)
    wr(1'b0, cmd(2'b01, 5'd3, 5'd9, 16'hA5C3));
    repeat (100) @(negedge clk);
    wr(1'b0, cmd(2'b10, 5'd30, 5'd1, 16'h1234));
    #1;
    check("R9 fields kept", {rd_data[27:16], rd_data[15:0]}, {12'({2'b01, 5'd9, 5'd3}), 16'hA5C3});
    wait_idle();
    check("R6 no rvalid after write", 32'(rd_data[29]), 0);

    // R7: read, own address updated while busy (R11)
    m_resp = 16'h3C5A;
    wr(1'b0, cmd(2'b10, 5'd31, 5'd17, 16'h0000));
    repeat (50) @(negedge clk);
    wr(1'b1, 32'h0000_0012);
    reg_sel = 1'b1; #1;
    check("R11 own while busy", rd_data, 32'h0000_0012);
    reg_sel = 1'b0;
    wait_idle();
    check("R7 read data", {16'd0, rd_data[15:0]}, 32'h0000_3C5A);
    check("R7 rvalid", 32'(rd_data[29]), 1);

    // R10: reserved opcodes start nothing
    wr(1'b0, cmd(2'b00, 5'd7, 5'd7, 16'hFFFF));
    wr(1'b0, cmd(2'b11, 5'd7, 5'd7, 16'hFFFF));
    #1;
    check("R10 not busy", 32'(rd_data[28]), 0);
    check("R10 data kept", {16'd0, rd_data[15:0]}, 32'h0000_3C5A);

    // R8: new command clears read-valid
    m_resp = 16'h8001;
    wr(1'b0, cmd(2'b10, 5'd0, 5'd31, 16'h0000));
    #1;
    check("R8 rvalid cleared", 32'(rd_data[29]), 0);
    wait_idle();
    check("R7 edge bits", {16'd0, rd_data[15:0]}, 32'h0000_8001);

    m_resp = 16'h0000;
    wr(1'b0, cmd(2'b10, 5'd21, 5'd10, 16'hFFFF));
    wait_idle();
    check("R7 zero data", {16'd0, rd_data[15:0]}, 0);

    wr(1'b0, cmd(2'b01, 5'd31, 5'd31, 16'hFFFF));
    wait_idle();
    check("R6 second write rvalid", 32'(rd_data[29]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule